// File: doc/BRIEF.md
# Signed 4x4 Array Multiplier

This block forms the two's-complement product of two 4-bit signed operands with no clock, register or handshake. Its datapath is a classic array: one row of AND gates per multiplier bit builds a partial product, and ripple chains of full adders sum the rows one after another. The result is an 8-bit signed product.

Signed operands are handled in front of the array. When the multiplier is negative, both operands are negated first. The product stays the same and the multiplier becomes a non-negative magnitude. The multiplicand is carried at 5 bits so that negating -8 still gives +8. Each partial-product row is then sign-extended from that 5-bit multiplicand to the full product width. A negative multiplicand therefore fills the upper bits of its rows with ones, and the modulo-256 sum of the rows is the signed product.

The block has no states. It computes its output anew whenever an input changes. A system uses it as a leaf arithmetic cell and places registers around it where timing demands.

Top module: `smul_array_mult`

## Requirements
- R1: For every one of the 256 pairs of 4-bit signed inputs, `product_o` equals the 8-bit two's-complement value of `mcand_i` times `mplier_i`.
- R2: If either operand is 0, `product_o` is 8'h00.
- R3: With `mplier_i` = 4'b0001, `product_o` equals `mcand_i` sign-extended to 8 bits.
- R4: With a negative `mplier_i` (bit 3 set), `product_o` equals the product of the negated operands: the multiplicand negated at 5 bits and the multiplier negated into a magnitude of at most 8.
- R5: With `mplier_i` = 2^k for k in {0,1,2}, `product_o` is the sign-extended `mcand_i` shifted left by k, with k zeros appended at the bottom.
- R6: Operands -8 and -8 give 8'h40 (+64), and -8 times -1 gives 8'h08. Negating -8 does not overflow.
- R7: When both operands are non-zero, bit 7 of `product_o` equals the XOR of the two operand sign bits (bit 3 of each).
- R8: With an even `mplier_i` (bit 0 clear), bit 0 of `product_o` is 0. Dropping that bit by an arithmetic right shift gives the product of `mcand_i` and `mplier_i`/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | 4 | Multiplicand, two's complement |
| mplier_i | input | 4 | Multiplier, two's complement |
| product_o | output | 8 | Signed product, two's complement |

## Verification
Two mechanisms can act on the same operand pair. One is sign extension of a negative multiplicand in every partial-product row. The other is negation of both operands when the multiplier is negative. They meet whenever both inputs are negative, and most sharply for -8 with -8, where the 5-bit negation turns the multiplicand into +8 while the multiplier magnitude lands on its top bit. The sweep covers every negative-by-negative pair, and directed vectors target the -8 corners. Each result is judged against a behavioural signed multiply evaluated in the bench. Where the requirements call for it, sign-bit and shift relations are also checked.

// File: rtl/smul_pkg.sv
package smul_pkg;
    // Default operand width of the multiplier array.
    localparam int unsigned SMUL_OP_W = 4;
endpackage

// File: rtl/smul_full_adder.sv
module smul_full_adder (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic gen;
    logic prop;

    always_comb begin
        gen  = a_i & b_i;
        prop = a_i | b_i;
        s_o  = a_i ^ b_i ^ c_i;
        c_o  = gen | (prop & c_i);
    end
endmodule

// File: rtl/smul_operand_prep.sv
module smul_operand_prep #(
    parameter int unsigned OP_W = 4,
    localparam int unsigned EXT_W = OP_W + 1
) (
    input  logic [OP_W-1:0]  mcand_i,
    input  logic [OP_W-1:0]  mplier_i,
    output logic [EXT_W-1:0] mc_o,   // signed multiplicand at one extra bit
    output logic [OP_W-1:0]  mp_o    // unsigned multiplier magnitude
);
    logic             flip;
    logic [EXT_W-1:0] mc_ext;

    always_comb begin
        flip   = mplier_i[OP_W-1];
        mc_ext = {mcand_i[OP_W-1], mcand_i};
        if (flip) begin
            // negate both operands; extra bit keeps -min representable
            mc_o = ~mc_ext + 1'b1;
            mp_o = ~mplier_i + 1'b1;
        end else begin
            mc_o = mc_ext;
            mp_o = mplier_i;
        end
    end
endmodule

// File: rtl/smul_pp_gen.sv
module smul_pp_gen #(
    parameter int unsigned OP_W = 4,
    localparam int unsigned EXT_W  = OP_W + 1,
    localparam int unsigned PROD_W = 2 * OP_W
) (
    input  logic [EXT_W-1:0]  mc_i,
    input  logic [OP_W-1:0]   mp_i,
    output logic [PROD_W-1:0] rows_o [OP_W]
);
    logic [PROD_W-1:0] mc_wide;

    // sign extension of the multiplicand across the product width
    assign mc_wide = {{(PROD_W-EXT_W){mc_i[EXT_W-1]}}, mc_i};

    for (genvar j = 0; j < OP_W; j++) begin : g_row
        logic [PROD_W-1:0] gated;
        assign gated     = mc_wide & {PROD_W{mp_i[j]}};
        assign rows_o[j] = gated << j;
    end
endmodule

// File: rtl/smul_adder_row.sv
module smul_adder_row #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < W - 1) begin : g_fa
            smul_full_adder u_fa (
                .a_i (x_i[i]),
                .b_i (y_i[i]),
                .c_i (carry[i]),
                .s_o (sum_o[i]),
                .c_o (carry[i+1])
            );
        end else begin : g_top
            // carry out of the top bit is discarded (modulo 2^W)
            assign sum_o[i] = x_i[i] ^ y_i[i] ^ carry[i];
        end
    end
endmodule

// File: rtl/smul_array_mult.sv
module smul_array_mult #(
    parameter int unsigned OP_W = smul_pkg::SMUL_OP_W,
    localparam int unsigned EXT_W  = OP_W + 1,
    localparam int unsigned PROD_W = 2 * OP_W
) (
    input  logic [OP_W-1:0]   mcand_i,
    input  logic [OP_W-1:0]   mplier_i,
    output logic [PROD_W-1:0] product_o
);
    logic [EXT_W-1:0]  mc_eff;
    logic [OP_W-1:0]   mp_eff;
    logic [PROD_W-1:0] rows [OP_W];
    logic [PROD_W-1:0] acc  [OP_W];

    smul_operand_prep #(.OP_W(OP_W)) u_prep (
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .mc_o     (mc_eff),
        .mp_o     (mp_eff)
    );

    smul_pp_gen #(.OP_W(OP_W)) u_pp (
        .mc_i   (mc_eff),
        .mp_i   (mp_eff),
        .rows_o (rows)
    );

    assign acc[0] = rows[0];

    for (genvar j = 1; j < OP_W; j++) begin : g_acc
        smul_adder_row #(.W(PROD_W)) u_row (
            .x_i   (acc[j-1]),
            .y_i   (rows[j]),
            .sum_o (acc[j])
        );
    end

    assign product_o = acc[OP_W-1];
endmodule

// File: rtl/smul_array_mult_chk.sv
module smul_array_mult_chk #(
    parameter int unsigned OP_W = 4,
    localparam int unsigned EXT_W  = OP_W + 1,
    localparam int unsigned PROD_W = 2 * OP_W
) (
    input logic [OP_W-1:0]   mcand_i,
    input logic [OP_W-1:0]   mplier_i,
    input logic [PROD_W-1:0] product_o,
    input logic [EXT_W-1:0]  mc_eff,
    input logic [OP_W-1:0]   mp_eff
);
    function automatic int sx(input logic [OP_W-1:0] v);
        return int'($signed(v));
    endfunction

    always_comb begin
        if (!$isunknown({mcand_i, mplier_i, product_o})) begin
            p_product_r1: assert (product_o == PROD_W'(sx(mcand_i) * sx(mplier_i)))
                else $error("product mismatch");
            if (mcand_i == '0 || mplier_i == '0) begin
                p_zero_r2: assert (product_o == '0) else $error("zero operand");
            end
            if (mplier_i[OP_W-1]) begin
                p_negated_r4: assert (product_o ==
                    PROD_W'(int'($signed(mc_eff)) * int'(mp_eff)))
                    else $error("negated operands disagree");
                p_magnitude_r4: assert (int'(mp_eff) <= (1 << (OP_W-1)))
                    else $error("magnitude out of range");
            end
            if (mcand_i != '0 && mplier_i != '0) begin
                p_sign_r7: assert (product_o[PROD_W-1] == (mcand_i[OP_W-1] ^ mplier_i[OP_W-1]))
                    else $error("sign bit");
            end
            if (!mplier_i[0]) begin
                p_even_r8: assert (product_o[0] == 1'b0) else $error("even lsb");
            end
        end
    end
endmodule

bind smul_array_mult smul_array_mult_chk #(.OP_W(OP_W)) u_chk (
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o),
    .mc_eff    (mc_eff),
    .mp_eff    (mp_eff)
);

// File: tb/tb_smul_array_mult.sv
module tb_smul_array_mult;
    logic       clk = 1'b0;
    logic [3:0] a = '0;
    logic [3:0] b = '0;
    logic [7:0] p;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    smul_array_mult dut (
        .mcand_i   (a),
        .mplier_i  (b),
        .product_o (p)
    );

    function automatic logic [7:0] ref_mul(input logic [3:0] x, input logic [3:0] y);
        int sx, sy;
        sx = x[3] ? int'(x) - 16 : int'(x);
        sy = y[3] ? int'(y) - 16 : int'(y);
        return 8'(sx * sy);
    endfunction

    function automatic logic [7:0] sext(input logic [3:0] x);
        return {{4{x[3]}}, x};
    endfunction

    task automatic cmp(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s a=%h b=%h got=%h exp=%h", req, a, b, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] x, input logic [3:0] y);
        @(negedge clk);
        a = x;
        b = y;
        @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'h5eed_0281));
        // idle state: zero operands
        apply(4'h0, 4'h0);
        cmp("R2", p, 8'h00);

        // R1, R7, R8 exhaustive sweep
        for (int i = 0; i < 16; i++) begin
            for (int k = 0; k < 16; k++) begin
                apply(4'(i), 4'(k));
                cmp("R1", p, ref_mul(a, b));
                if (a != 0 && b != 0)
                    cmp("R7", {7'd0, p[7]}, {7'd0, a[3] ^ b[3]});
                if (!b[0]) begin
                    cmp("R8", {7'd0, p[0]}, 8'h00);
                    cmp("R8", 8'($signed(p) >>> 1), ref_mul(a, {b[3], b[3:1]}));
                end
                if (a == 0 || b == 0) cmp("R2", p, 8'h00);
            end
        end

        // R3 and R5: powers of two
        for (int i = 0; i < 16; i++) begin
            apply(4'(i), 4'b0001);
            cmp("R3", p, sext(a));
            for (int k = 0; k < 3; k++) begin
                apply(4'(i), 4'(1 << k));
                cmp("R5", p, sext(a) << k);
            end
        end

        // R4 negative multiplier, R6 corners
        apply(4'h8, 4'h8); cmp("R6", p, 8'h40);
        apply(4'h8, 4'hF); cmp("R6", p, 8'h08);
        apply(4'h8, 4'h7); cmp("R6", p, 8'hC8);
        apply(4'h7, 4'h8); cmp("R4", p, 8'hC8);
        apply(4'hB, 4'hC); cmp("R4", p, 8'h14);  // -5 * -4 = 20
        apply(4'h5, 4'hC); cmp("R4", p, 8'hEC);  // 5 * -4 = -20

        // random mix
        for (int n = 0; n < 300; n++) begin
            apply(4'($urandom), 4'($urandom));
            cmp(b[3] ? "R4" : "R1", p, ref_mul(a, b));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule